// File: doc/BRIEF.md
# Interrupt Redirection Router

This block routes sixteen interrupt input lines to processor interrupt messages. Software programs it through two 32-bit locations on a register bus: a select location that holds an internal register index, and a data window that reads or writes the register that index names. Each input line owns a 64-bit routing entry. The entry holds the vector, a mask, a trigger kind, a destination kind, a delivery kind and a destination identifier.

Every line's level is tracked from cycle to cycle. A transition to asserted on a line whose entry is deliverable latches a request. Requests leave one at a time on a valid/ready message port that carries the vector, the destination and a broadcast flag. A level-triggered line that asserts while masked is remembered as pending. The interrupt is replayed when software unmasks the entry and the line is still high.

Top module: `irq_redirector`

## Requirements
- R1: An access is taken only when `bus_be` is 4'hF and `bus_addr` is 8'h00 (select) or 8'h10 (window). Any other access leaves all state unchanged and reads 0.
- R2: The window acts on the register whose index is `select[7:0]`. The select location reads back all 32 bits written to it. An index with no register (for example 8'h05 or 8'h30) reads 0.
- R3: Line n's entry uses index 8'h10+2n for bits 31:0 and index 8'h11+2n for bits 63:32. A window write changes only the half it addresses.
- R4: After reset, every entry reads 64'h0001_0000_0001_0000, which means every line is masked. The select and identifier registers read 0, no message is valid, and a rising line produces no message.
- R5: Index 8'h00 holds a 4-bit identifier in bits 27:24, and every other bit reads 0. Index 8'h02 is read-only and reads the same identifier. Index 8'h01 is read-only and reads 32'h0010_0011: 0x11 in bits 7:0 and the entry count 16 in bits 23:16.
- R6: Only a low-to-high change of a line is evaluated for delivery. Holding a line high, or lowering it, produces no message.
- R7: An entry is deliverable when all three of these hold: the mask bit 16 is 0, the destination kind bit 11 is 0 (physical), and the delivery kind bits 10:8 are 000 (fixed). The message vector is entry bits 7:0 and the destination is bits 63:56. The broadcast flag is 1 exactly when the destination is 8'hFF.
- R8: A rise on a masked entry with bit 15 = 1 (level-triggered) sets that line's pending flag and sends nothing. A rise on a masked entry with bit 15 = 0 (edge-triggered) is dropped.
- R9: A window write to either half of an entry that leaves bit 16 at 0 clears that line's pending flag. If the line is still high and the entry is deliverable, the interrupt is sent. If the line is low, nothing is sent.
- R10: `msg_valid` stays high until `msg_ready` is seen. The message is consumed on the cycle where both are high.
- R11: When several lines hold requests, the lowest-numbered line is offered first. The others stay latched and follow in ascending order.
- R12: A line that toggles while its own request waits for `msg_ready` yields exactly one message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Register bus write strobe |
| bus_rd_en | input | 1 | Register bus read strobe |
| bus_addr | input | 8 | Byte offset within the block |
| bus_be | input | 4 | Byte enables; only 4'hF is accepted |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on the read strobe |
| irq_lines | input | 16 | Interrupt input lines, high = asserted |
| msg_valid | output | 1 | Interrupt message available |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_vector | output | 8 | Message vector |
| msg_dest | output | 8 | Message destination identifier |
| msg_bcast | output | 1 | Message goes to every processor |

## Verification
Two functions can fall in the same cycle.

- **Simultaneous rises and arbitration.** Several lines are raised on one clock while `msg_ready` is held low. The bench then drains the port and judges the vectors against the ascending order it predicts, then confirms nothing extra follows.
- **Toggling while a request waits.** A line is toggled while its own request is still waiting, and the bench requires a single message.
- **Unmask replay against a lowered line.** A masked level-triggered line is raised, and the entry is then unmasked with the line still high in one case and already low in the other. The replayed message is compared with the bench's own model of the entry.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

  localparam logic [63:0] ENTRY_RST = 64'h0001_0000_0001_0000;

  localparam logic [7:0] OFS_SEL = 8'h00;
  localparam logic [7:0] OFS_WIN = 8'h10;

  localparam logic [7:0] IDX_ID  = 8'h00;
  localparam logic [7:0] IDX_VER = 8'h01;
  localparam logic [7:0] IDX_ARB = 8'h02;
  localparam int unsigned IDX_TBL = 16;

  typedef struct packed {
    logic [7:0] vector;
    logic [7:0] dest;
    logic       bcast;
  } irq_msg_t;

  function automatic logic entry_masked(input logic [63:0] e);
    return e[16];
  endfunction

  function automatic logic entry_level(input logic [63:0] e);
    return e[15];
  endfunction

  function automatic logic entry_deliverable(input logic [63:0] e);
    return (e[16] == 1'b0) && (e[11] == 1'b0) && (e[10:8] == 3'b000);
  endfunction

  function automatic irq_msg_t entry_to_msg(input logic [63:0] e);
    irq_msg_t m;
    m.vector = e[7:0];
    m.dest   = e[63:56];
    m.bcast  = (e[63:56] == 8'hFF);
    return m;
  endfunction

  function automatic logic [31:0] version_word(input int unsigned n);
    return {8'h00, 8'(n), 16'h0011};
  endfunction

endpackage

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_redir_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [7:0]             addr,
  input  logic [3:0]             be,
  input  logic [31:0]            wdata,
  output logic [31:0]            rdata,
  output logic [NPINS-1:0][63:0] entries_o,
  output logic [NPINS-1:0]       entry_wr_o
);

  localparam int unsigned PIN_W   = $clog2(NPINS);
  localparam int unsigned TBL_END = IDX_TBL + 2 * NPINS;

  logic [31:0]            sel_q;
  logic [3:0]             id_q;
  logic [NPINS-1:0][63:0] entry_q;
  logic [NPINS-1:0]       wr_pulse_q;

  logic                   access_ok;
  logic                   win_wr;
  logic                   sel_wr;
  logic [7:0]             idx;
  logic                   tbl_hit;
  logic [7:0]             tbl_off;
  logic [PIN_W-1:0]       tbl_pin;
  logic                   tbl_hi;
  logic                   tbl_wr;
  logic [31:0]            win_val;

  assign access_ok = (be == 4'hF) && ((addr == OFS_SEL) || (addr == OFS_WIN));
  assign sel_wr    = wr_en && access_ok && (addr == OFS_SEL);
  assign win_wr    = wr_en && access_ok && (addr == OFS_WIN);
  assign idx       = sel_q[7:0];
  assign tbl_hit   = (int'(idx) >= int'(IDX_TBL)) && (int'(idx) < int'(TBL_END));
  assign tbl_off   = idx - 8'(IDX_TBL);
  assign tbl_pin   = tbl_off[PIN_W:1];
  assign tbl_hi    = tbl_off[0];
  assign tbl_wr    = win_wr && tbl_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (sel_wr) sel_q <= wdata;
      if (win_wr && (idx == IDX_ID)) id_q <= wdata[27:24];
    end
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_entry
    localparam logic [PIN_W-1:0] MY_PIN = PIN_W'(p);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        entry_q[p]    <= ENTRY_RST;
        wr_pulse_q[p] <= 1'b0;
      end else begin
        wr_pulse_q[p] <= tbl_wr && (tbl_pin == MY_PIN);
        if (tbl_wr && (tbl_pin == MY_PIN)) begin
          if (tbl_hi) entry_q[p][63:32] <= wdata;
          else        entry_q[p][31:0]  <= wdata;
        end
      end
    end
  end

  always_comb begin
    win_val = '0;
    if ((idx == IDX_ID) || (idx == IDX_ARB)) win_val = {4'h0, id_q, 24'h0};
    else if (idx == IDX_VER)                 win_val = version_word(NPINS);
    else if (tbl_hit)
      win_val = tbl_hi ? entry_q[tbl_pin][63:32] : entry_q[tbl_pin][31:0];
  end

  always_comb begin
    rdata = '0;
    if (rd_en && access_ok) rdata = (addr == OFS_SEL) ? sel_q : win_val;
  end

  assign entries_o  = entry_q;
  assign entry_wr_o = wr_pulse_q;

  // A select write with partial byte enables must not alter the select register.
  assert_sel_ignore_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == OFS_SEL) && (be != 4'hF)) |=> $stable(sel_q));

  // Reading the identifier register exposes nothing outside bits 27:24.
  assert_id_field_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && access_ok && (addr == OFS_WIN) && (idx == IDX_ID))
      |-> ((rdata[31:28] == 4'h0) && (rdata[23:0] == 24'h0)));

endmodule

// File: rtl/irq_pin_ctl.sv
module irq_pin_ctl
  import irq_redir_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPINS-1:0]       pins_i,
  input  logic [NPINS-1:0][63:0] entries_i,
  input  logic [NPINS-1:0]       entry_wr_i,
  input  logic [NPINS-1:0]       grant_i,
  output logic [NPINS-1:0]       req_o
);

  logic [NPINS-1:0] level_q;
  logic [NPINS-1:0] pend_q;
  logic [NPINS-1:0] req_q;

  // Named per-line events, visible to the assertions below.
  logic [NPINS-1:0] rise_evt;
  logic [NPINS-1:0] replay_evt;
  logic [NPINS-1:0] fire_evt;
  logic [NPINS-1:0] park_evt;

  for (genvar p = 0; p < NPINS; p++) begin : g_line
    assign rise_evt[p]   = pins_i[p] && !level_q[p];
    assign replay_evt[p] = entry_wr_i[p] && pend_q[p] && !entry_masked(entries_i[p]);
    assign fire_evt[p]   = (rise_evt[p] || (replay_evt[p] && level_q[p]))
                           && entry_deliverable(entries_i[p]);
    assign park_evt[p]   = rise_evt[p] && entry_masked(entries_i[p])
                           && entry_level(entries_i[p]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        level_q[p] <= 1'b0;
        pend_q[p]  <= 1'b0;
        req_q[p]   <= 1'b0;
      end else begin
        level_q[p] <= pins_i[p];
        if (replay_evt[p])    pend_q[p] <= 1'b0;
        else if (park_evt[p]) pend_q[p] <= 1'b1;
        req_q[p] <= (req_q[p] && !grant_i[p]) || fire_evt[p];
      end
    end

    // An unmasking write always leaves the line without a pending flag.
    assert_replay_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (entry_wr_i[p] && !entries_i[p][16]) |=> !pend_q[p]);

    // With no rise and no entry write, an idle line stays idle.
    assert_no_fall_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!pins_i[p] && !req_q[p] && !entry_wr_i[p]) |=> !req_q[p]);
  end

  assign req_o = req_q;

endmodule

// File: rtl/irq_msg_arb.sv
module irq_msg_arb
  import irq_redir_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPINS-1:0]       req_i,
  input  logic [NPINS-1:0][63:0] entries_i,
  input  logic                   ready_i,
  output logic                   valid_o,
  output irq_msg_t               msg_o,
  output logic [NPINS-1:0]       grant_o
);

  localparam int unsigned PIN_W = $clog2(NPINS);

  logic [NPINS-1:0] win_oh;
  logic [PIN_W-1:0] win_idx;
  logic             found;

  always_comb begin
    win_oh  = '0;
    win_idx = '0;
    found   = 1'b0;
    for (int i = 0; i < NPINS; i++) begin
      if (req_i[i] && !found) begin
        found     = 1'b1;
        win_oh[i] = 1'b1;
        win_idx   = PIN_W'(i);
      end
    end
  end

  assign valid_o = found;
  assign msg_o   = entry_to_msg(entries_i[win_idx]);
  assign grant_o = (valid_o && ready_i) ? win_oh : '0;

  // An offered message is withdrawn only after the consumer takes it.
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> valid_o);

endmodule

// File: rtl/irq_redirector.sv
module irq_redirector
  import irq_redir_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr_en,
  input  logic             bus_rd_en,
  input  logic [7:0]       bus_addr,
  input  logic [3:0]       bus_be,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] irq_lines,
  output logic             msg_valid,
  input  logic             msg_ready,
  output logic [7:0]       msg_vector,
  output logic [7:0]       msg_dest,
  output logic             msg_bcast
);

  logic [NPINS-1:0][63:0] entries;
  logic [NPINS-1:0]       entry_wr;
  logic [NPINS-1:0]       req;
  logic [NPINS-1:0]       grant;
  irq_msg_t               msg;

  irq_regfile #(.NPINS(NPINS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (bus_wr_en),
    .rd_en     (bus_rd_en),
    .addr      (bus_addr),
    .be        (bus_be),
    .wdata     (bus_wdata),
    .rdata     (bus_rdata),
    .entries_o (entries),
    .entry_wr_o(entry_wr)
  );

  irq_pin_ctl #(.NPINS(NPINS)) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .pins_i    (irq_lines),
    .entries_i (entries),
    .entry_wr_i(entry_wr),
    .grant_i   (grant),
    .req_o     (req)
  );

  irq_msg_arb #(.NPINS(NPINS)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req),
    .entries_i(entries),
    .ready_i  (msg_ready),
    .valid_o  (msg_valid),
    .msg_o    (msg),
    .grant_o  (grant)
  );

  assign msg_vector = msg.vector;
  assign msg_dest   = msg.dest;
  assign msg_bcast  = msg.bcast;

endmodule

// File: tb/irq_redirector_test.sv
`timescale 1ns/1ps
module irq_redirector_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] irq_lines = '0;
  logic        msg_valid, msg_ready = 1'b0, msg_bcast;
  logic [7:0]  msg_vector, msg_dest;

  int n_chk = 0;
  int n_fail = 0;
  logic [63:0] m_ent [16];

  always #2 clk = ~clk;

  irq_redirector uut (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_lines(irq_lines), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_vector(msg_vector), .msg_dest(msg_dest), .msg_bcast(msg_bcast)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_entry(input logic [7:0] vec, input logic [7:0] dst,
      input bit masked, input bit lvl, input bit logical, input logic [2:0] dm);
    logic [63:0] e = '0;
    e[7:0] = vec; e[10:8] = dm; e[11] = logical; e[15] = lvl; e[16] = masked;
    e[63:56] = dst;
    return e;
  endfunction

  function automatic bit exp_deliver(input logic [63:0] e);
    return !e[16] && !e[11] && (e[10:8] == 3'b000);
  endfunction

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d; bus_be = b;
    @(negedge clk);
    bus_wr_en = 1'b0; bus_be = '0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [3:0] b, output logic [31:0] d);
    @(negedge clk);
    bus_rd_en = 1'b1; bus_addr = a; bus_be = b;
    #1 d = bus_rdata;
    bus_rd_en = 1'b0; bus_be = '0;
  endtask

  task automatic reg_wr(input logic [7:0] i, input logic [31:0] d);
    bus_wr(8'h00, {24'h0, i}, 4'hF);
    bus_wr(8'h10, d, 4'hF);
  endtask

  task automatic reg_rd(input logic [7:0] i, output logic [31:0] d);
    bus_wr(8'h00, {24'h0, i}, 4'hF);
    bus_rd(8'h10, 4'hF, d);
  endtask

  task automatic entry_wr(input int p, input logic [63:0] e);
    reg_wr(8'(8'h11 + 2 * p), e[63:32]);
    reg_wr(8'(8'h10 + 2 * p), e[31:0]);
    m_ent[p] = e;
  endtask

  task automatic pin_set(input int p, input logic v);
    @(negedge clk);
    irq_lines[p] = v;
  endtask

  task automatic expect_msg(input logic [63:0] e, input string tag);
    @(negedge clk);
    #1;
    check(msg_valid === 1'b1, {tag, " valid"}, 64'(msg_valid), 64'd1);
    check(msg_vector === e[7:0], {tag, " vector"}, 64'(msg_vector), 64'(e[7:0]));
    check(msg_dest === e[63:56], {tag, " dest"}, 64'(msg_dest), 64'(e[63:56]));
    check(msg_bcast === (e[63:56] == 8'hFF), {tag, " bcast"}, 64'(msg_bcast),
          64'(e[63:56] == 8'hFF));
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic expect_none(input string tag);
    repeat (2) @(negedge clk);
    #1 check(msg_valid === 1'b0, {tag, " no message"}, 64'(msg_valid), 64'd0);
  endtask

  initial begin : watchdog
    #800000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    logic [63:0] e;
    int seed_set;
    seed_set = $urandom(32'h5EED_0042);
    for (int i = 0; i < 16; i++) m_ent[i] = 64'h0001_0000_0001_0000;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R4 reset state
    #1 check(msg_valid === 1'b0, "R4 valid after reset", 64'(msg_valid), 0);
    bus_rd(8'h00, 4'hF, d); check(d == 0, "R4 select reset", 64'(d), 0);
    reg_rd(8'h10, d); check(d == 32'h0001_0000, "R4 entry0 low", 64'(d), 64'h10000);
    reg_rd(8'h11, d); check(d == 32'h0001_0000, "R4 entry0 high", 64'(d), 64'h10000);
    reg_rd(8'h2F, d); check(d == 32'h0001_0000, "R4 entry15 high", 64'(d), 64'h10000);
    reg_rd(8'h00, d); check(d == 0, "R4 id reset", 64'(d), 0);
    pin_set(0, 1'b1); expect_none("R4 masked at reset"); pin_set(0, 1'b0);

    // R5 id / arbitration / version
    reg_wr(8'h00, 32'hFFFF_FFFF);
    reg_rd(8'h00, d); check(d == 32'h0F00_0000, "R5 id field", 64'(d), 64'h0F00_0000);
    reg_rd(8'h02, d); check(d == 32'h0F00_0000, "R5 arb mirrors id", 64'(d), 64'h0F00_0000);
    reg_wr(8'h01, 32'h0);
    reg_rd(8'h01, d); check(d == 32'h0010_0011, "R5 version", 64'(d), 64'h0010_0011);
    reg_wr(8'h02, 32'h0);
    reg_rd(8'h00, d); check(d == 32'h0F00_0000, "R5 arb read-only", 64'(d), 64'h0F00_0000);

    // R2 select / window decode
    reg_rd(8'h05, d); check(d == 0, "R2 unmapped 0x05", 64'(d), 0);
    reg_rd(8'h30, d); check(d == 0, "R2 unmapped 0x30", 64'(d), 0);
    bus_wr(8'h00, 32'hABCD_1210, 4'hF);
    bus_rd(8'h00, 4'hF, d); check(d == 32'hABCD_1210, "R2 select readback", 64'(d), 64'hABCD_1210);
    bus_rd(8'h10, 4'hF, d); check(d == 32'h0001_0000, "R2 low byte index", 64'(d), 64'h10000);

    // R1 rejected accesses
    bus_wr(8'h00, 32'h11, 4'h3);
    bus_rd(8'h00, 4'hF, d); check(d == 32'hABCD_1210, "R1 partial select write", 64'(d), 64'hABCD_1210);
    bus_wr(8'h08, 32'h11, 4'hF);
    bus_rd(8'h00, 4'hF, d); check(d == 32'hABCD_1210, "R1 bad offset write", 64'(d), 64'hABCD_1210);
    bus_rd(8'h10, 4'h1, d); check(d == 0, "R1 partial read", 64'(d), 0);
    bus_rd(8'h04, 4'hF, d); check(d == 0, "R1 bad offset read", 64'(d), 0);
    bus_wr(8'h00, 32'h12, 4'hF);
    bus_wr(8'h10, 32'h55, 4'h7);
    reg_rd(8'h12, d); check(d == 32'h0001_0000, "R1 partial window write", 64'(d), 64'h10000);

    // R3 half write
    reg_wr(8'h13, 32'hDEAD_0000);
    reg_rd(8'h12, d); check(d == 32'h0001_0000, "R3 low half kept", 64'(d), 64'h10000);
    reg_rd(8'h13, d); check(d == 32'hDEAD_0000, "R3 high half written", 64'(d), 64'hDEAD_0000);
    entry_wr(1, 64'h0001_0000_0001_0000);

    // R7 delivery rules
    e = mk_entry(8'h42, 8'hFF, 0, 0, 0, 3'b000); entry_wr(2, e);
    pin_set(2, 1); expect_msg(e, "R7 broadcast"); pin_set(2, 0);
    e = mk_entry(8'h43, 8'h07, 0, 0, 0, 3'b000); entry_wr(2, e);
    pin_set(2, 1); expect_msg(e, "R7 unicast");
    // R6 hold high, then fall
    expect_none("R6 held high"); pin_set(2, 0); expect_none("R6 fall");
    e = mk_entry(8'h44, 8'h07, 0, 0, 1, 3'b000); entry_wr(2, e);
    pin_set(2, 1); expect_none("R7 logical dropped"); pin_set(2, 0);
    e = mk_entry(8'h45, 8'h07, 0, 0, 0, 3'b001); entry_wr(2, e);
    pin_set(2, 1); expect_none("R7 non-fixed dropped"); pin_set(2, 0);

    // R8 / R9 pending and replay
    e = mk_entry(8'h33, 8'h05, 1, 1, 0, 3'b000); entry_wr(3, e);
    pin_set(3, 1); expect_none("R8 masked level parks");
    e[16] = 1'b0; entry_wr(3, e); expect_msg(e, "R9 replay on unmask");
    expect_none("R9 single replay");
    pin_set(3, 0);
    e[16] = 1'b1; entry_wr(3, e);
    pin_set(3, 1); pin_set(3, 0); expect_none("R8 parked again");
    e[16] = 1'b0; entry_wr(3, e); expect_none("R9 unmask with line low");
    e = mk_entry(8'h34, 8'h05, 1, 0, 0, 3'b000); entry_wr(4, e);
    pin_set(4, 1); expect_none("R8 masked edge");
    e[16] = 1'b0; entry_wr(4, e); expect_none("R8 edge not replayed");
    pin_set(4, 0);

    // R10 hold while not ready
    e = mk_entry(8'h50, 8'h01, 0, 0, 0, 3'b000); entry_wr(5, e);
    pin_set(5, 1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
      check(msg_valid === 1'b1 && msg_vector === 8'h50, "R10 held", 64'(msg_vector), 64'h50);
    end
    expect_msg(e, "R10 accepted"); expect_none("R10 consumed"); pin_set(5, 0);

    // R11 lowest first
    entry_wr(6, mk_entry(8'h60, 8'h02, 0, 0, 0, 3'b000));
    entry_wr(7, mk_entry(8'h70, 8'h03, 0, 0, 0, 3'b000));
    @(negedge clk); irq_lines[7:5] = 3'b111;
    expect_msg(m_ent[5], "R11 first");
    expect_msg(m_ent[6], "R11 second");
    expect_msg(m_ent[7], "R11 third");
    expect_none("R11 drained");
    @(negedge clk); irq_lines[7:5] = 3'b000;

    // R12 toggle while waiting
    e = mk_entry(8'h88, 8'h09, 0, 1, 0, 3'b000); entry_wr(8, e);
    pin_set(8, 1);
    for (int k = 0; k < 3; k++) begin pin_set(8, 0); pin_set(8, 1); end
    expect_msg(e, "R12 one message"); expect_none("R12 no duplicate"); pin_set(8, 0);

    // Random mix, R6 / R7 / R8
    for (int it = 0; it < 60; it++) begin
      int p;
      logic [7:0] dst;
      p = int'($urandom % 16);
      dst = ($urandom % 8 == 0) ? 8'hFF : 8'($urandom);
      e = mk_entry(8'($urandom), dst, ($urandom % 4 == 0), 1'($urandom),
                   ($urandom % 6 == 0), ($urandom % 5 == 0) ? 3'($urandom % 7 + 1) : 3'b000);
      entry_wr(p, e);
      pin_set(p, 1);
      if (exp_deliver(e)) expect_msg(e, "R7 random delivery");
      else                expect_none("R7 random drop");
      pin_set(p, 0);
    end

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule